// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block loads a configuration image into an SRAM-based FPGA that listens as an SPI slave. It owns the target's active-low reset line, its chip-select, clock and data-in lines, and it watches the target's done flag. A start pulse begins one run. The image arrives one byte at a time on a valid/ready stream, and the final byte carries an end marker.

A run walks a fixed power-up protocol. The block pulses the target reset with chip-select held low. It checks that the target really came out of configuration, waits out the target's internal housekeeping with chip-select still low, and then opens a fresh chip-select window for the image. It shifts the image in SPI mode 0. After the last byte it checks the done flag again. On success it clocks zero bytes to wake the loaded design. The result comes back as a success flag or a two-bit error code. Each result holds until the next start.

The states are IDLE, RST_HOLD, RST_CHECK, HOUSEKEEP, CS_GAP, STREAM, DONE_CHECK and ACTIVATE. The transitions are:
- IDLE goes to RST_HOLD on a full start. A partial-reconfiguration start stays in IDLE.
- RST_HOLD goes to RST_CHECK when the hold timer ends.
- RST_CHECK goes to IDLE if the done flag is high, and to HOUSEKEEP if it is low.
- HOUSEKEEP goes to CS_GAP when its timer ends.
- CS_GAP goes to STREAM when its timer ends.
- STREAM goes to DONE_CHECK when the end-marked byte has finished shifting.
- DONE_CHECK goes to IDLE if the done flag is low, and to ACTIVATE if it is high.
- ACTIVATE goes to IDLE after the last padding byte.

Top module: `cfg_seq`

## Requirements
- R1: A start with `partial_i` low drives `tgt_reset_n_o` low and `tgt_cs_n_o` low on the same clock edge. The reset stays low for exactly ceil(RESET_HOLD_NS × CLK_MHZ / 1000) cycles. RESET_HOLD_NS must be at least 200 and defaults to 1000.
- R2: The reset line is released while chip-select stays low, and chip-select is never high while the reset line is low.
- R3: The done flag is sampled in the first cycle after reset release. If it is high, the run ends on the next edge with error code 2'b01 (reset failed), chip-select high and busy low.
- R4: If the done flag is low at that check, chip-select stays low for HOUSEKEEP_US × CLK_MHZ further cycles. It then goes high for exactly 2 × SCLK_HALF cycles with no SCLK activity before the image begins.
- R5: Image bytes are shifted most significant bit first in SPI mode 0:
  - SCLK idles low, and MOSI changes only while SCLK is low.
  - Each SCLK high phase lasts SCLK_HALF clock cycles.
  - Chip-select is low at every SCLK rising edge.
- R6: Elaboration fails when RESET_HOLD_NS is below 200, or when the SCLK rate CLK_MHZ / (2 × SCLK_HALF) MHz lies outside 1 to 25 MHz.
- R7: If the done flag is low once the end-marked byte has shifted, the run ends with error code 2'b10 (not configured), chip-select high, and no further SCLK.
- R8: If the done flag is high at that point, the block shifts ceil(ACT_BITS / 8) zero bytes (7 by default, 56 clocks). It then ends with `ok_o` high and error code 2'b00.
- R9: A start with `partial_i` high sets error code 2'b11 (unsupported) on the next edge. Busy stays low, and the reset line, chip-select and SCLK do not move.
- R10: Busy rises on the edge that accepts a full start and falls on the edge that posts the result. Any start clears `ok_o` and the error code on its accepting edge, and the result then holds until the next start.
- R11: `operating_o` follows the done flag one cycle later while the block is idle, and is low while busy.
- R12: `in_ready_o` is high only in the streaming phase, while no byte is being shifted and the end-marked byte has not yet been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start request, taken only when idle |
| partial_i | input | 1 | Start asks for partial reconfiguration (rejected) |
| in_data_i | input | 8 | Image byte |
| in_valid_i | input | 1 | Image byte valid |
| in_last_i | input | 1 | Image byte is the last of the image |
| in_ready_o | output | 1 | Block takes the offered byte on this edge |
| tgt_reset_n_o | output | 1 | Target reset, active low |
| tgt_cs_n_o | output | 1 | Target chip-select, active low |
| tgt_sclk_o | output | 1 | SPI clock to target |
| tgt_mosi_o | output | 1 | SPI data to target |
| tgt_done_i | input | 1 | Target configuration-done flag |
| busy_o | output | 1 | Run in progress |
| ok_o | output | 1 | Last run succeeded |
| err_o | output | 2 | Last run error code: 00 none, 01 reset failed, 10 not configured, 11 unsupported |
| operating_o | output | 1 | Idle and the target reports done |

## Verification
Two functions can meet in one cycle. When a start arrives in IDLE, clearing the held result and posting a new unsupported rejection happen on the same edge. The bench provokes this by leaving a not-configured code (2'b10) in place and then issuing a partial start. It expects 2'b11 on the very next edge, with no intermediate 2'b00 and with busy never rising. A following full start must then clear the code to 2'b00 on its own accepting edge. Image and padding bytes are pushed into a scoreboard and compared bit-exactly against what the SPI pins carry. Any extra or missing padding byte shows up as a scoreboard miscompare.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_HOLD,
        ST_RST_CHECK,
        ST_HOUSEKEEP,
        ST_CS_GAP,
        ST_STREAM,
        ST_DONE_CHECK,
        ST_ACTIVATE
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE           = 2'b00,
        ERR_RESET_FAIL     = 2'b01,
        ERR_NOT_CONFIGURED = 2'b10,
        ERR_UNSUPPORTED    = 2'b11
    } seq_err_e;

endpackage

// File: rtl/cfg_delay_timer.sv
// Down-counting delay timer: load N-1 to stay N cycles in a state.
module cfg_delay_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R4: an expired timer stays expired until reloaded (no wrap).
    a_r4_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/cfg_spi_shifter.sv
// Mode-0 byte shifter: MSB first, SCLK idles low, MOSI moves on falling phase.
module cfg_spi_shifter #(
    parameter int HALF = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] data_i,
    output logic       active_o,
    output logic       sclk_o,
    output logic       mosi_o
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] PHASE_END = CW'(HALF - 1);

    logic [7:0]    shreg_q;
    logic [2:0]    bit_q;
    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic          sclk_q;
    logic          mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bit_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            mosi_q   <= 1'b0;
        end else if (load_i && !active_q) begin
            shreg_q  <= data_i;
            mosi_q   <= data_i[7];
            active_q <= 1'b1;
            sclk_q   <= 1'b0;
            cnt_q    <= '0;
            bit_q    <= '0;
        end else if (active_q) begin
            if (cnt_q == PHASE_END) begin
                cnt_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        mosi_q   <= 1'b0;
                    end else begin
                        bit_q   <= bit_q + 3'd1;
                        shreg_q <= {shreg_q[6:0], 1'b0};
                        mosi_q  <= shreg_q[6];
                    end
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign sclk_o   = sclk_q;
    assign mosi_o   = mosi_q;

    // R5: data is steady across the whole SCLK high phase.
    a_r5_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(mosi_q));

    // R5: SCLK rests low whenever no byte is in flight.
    a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !sclk_q);

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int CLK_MHZ       = 200,
    parameter int RESET_HOLD_NS = 1000,
    parameter int HOUSEKEEP_US  = 1200,
    parameter int SCLK_HALF     = 5,
    parameter int ACT_BITS      = 49
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       partial_i,
    input  logic [7:0] in_data_i,
    input  logic       in_valid_i,
    input  logic       in_last_i,
    output logic       in_ready_o,
    output logic       tgt_reset_n_o,
    output logic       tgt_cs_n_o,
    output logic       tgt_sclk_o,
    output logic       tgt_mosi_o,
    input  logic       tgt_done_i,
    output logic       busy_o,
    output logic       ok_o,
    output logic [1:0] err_o,
    output logic       operating_o
);

    localparam int RST_CYC   = (RESET_HOLD_NS * CLK_MHZ + 999) / 1000;
    localparam int HK_CYC    = HOUSEKEEP_US * CLK_MHZ;
    localparam int GAP_CYC   = 2 * SCLK_HALF;
    localparam int ACT_BYTES = (ACT_BITS + 7) / 8;
    localparam int MAX_A     = (HK_CYC > RST_CYC) ? HK_CYC : RST_CYC;
    localparam int MAX_CYC   = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
    localparam int TW        = $clog2(MAX_CYC + 1);
    localparam int PW        = $clog2(ACT_BYTES + 1);

    // R6: elaboration-time limits on reset hold and SCLK rate.
    if (RESET_HOLD_NS < 200) begin : g_bad_hold
        $error("cfg_seq: reset hold below 200 ns");
    end
    if (CLK_MHZ > 2 * SCLK_HALF * 25) begin : g_sclk_fast
        $error("cfg_seq: SCLK above 25 MHz");
    end
    if (CLK_MHZ < 2 * SCLK_HALF) begin : g_sclk_slow
        $error("cfg_seq: SCLK below 1 MHz");
    end

    seq_state_e    state_q, state_d;
    seq_err_e      err_q, err_val;
    logic          err_set, ok_set;
    logic          ok_q, busy_q, op_q;
    logic          rst_n_q, cs_n_q;
    logic          last_seen_q;
    logic [PW-1:0] pad_left_q;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic          tx_load, tx_active;
    logic [7:0]    tx_data;
    logic          accept;
    logic          ready;

    cfg_delay_timer #(.W(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .value_i   (tmr_val),
        .expired_o (tmr_expired)
    );

    cfg_spi_shifter #(.HALF(SCLK_HALF)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tx_load),
        .data_i   (tx_data),
        .active_o (tx_active),
        .sclk_o   (tgt_sclk_o),
        .mosi_o   (tgt_mosi_o)
    );

    assign ready  = (state_q == ST_STREAM) && !tx_active && !last_seen_q;
    assign accept = ready && in_valid_i;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and per-cycle control.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tx_load  = 1'b0;
        tx_data  = in_data_i;
        err_set  = 1'b0;
        err_val  = ERR_NONE;
        ok_set   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (partial_i) begin
                        err_set = 1'b1;
                        err_val = ERR_UNSUPPORTED;
                    end else begin
                        state_d  = ST_RST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(RST_CYC - 1);
                    end
                end
            end
            ST_RST_HOLD: begin
                if (tmr_expired) state_d = ST_RST_CHECK;
            end
            ST_RST_CHECK: begin
                if (tgt_done_i) begin
                    err_set = 1'b1;
                    err_val = ERR_RESET_FAIL;
                    state_d = ST_IDLE;
                end else begin
                    state_d  = ST_HOUSEKEEP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HK_CYC - 1);
                end
            end
            ST_HOUSEKEEP: begin
                if (tmr_expired) begin
                    state_d  = ST_CS_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(GAP_CYC - 1);
                end
            end
            ST_CS_GAP: begin
                if (tmr_expired) state_d = ST_STREAM;
            end
            ST_STREAM: begin
                tx_load = accept;
                if (last_seen_q && !tx_active) state_d = ST_DONE_CHECK;
            end
            ST_DONE_CHECK: begin
                if (!tgt_done_i) begin
                    err_set = 1'b1;
                    err_val = ERR_NOT_CONFIGURED;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_ACTIVATE;
                end
            end
            ST_ACTIVATE: begin
                tx_data = 8'h00;
                if (!tx_active) begin
                    if (pad_left_q != '0) begin
                        tx_load = 1'b1;
                    end else begin
                        ok_set  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered outputs and result holding, aligned with the state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_n_q     <= 1'b1;
            cs_n_q      <= 1'b1;
            busy_q      <= 1'b0;
            ok_q        <= 1'b0;
            err_q       <= ERR_NONE;
            op_q        <= 1'b0;
            last_seen_q <= 1'b0;
            pad_left_q  <= '0;
        end else begin
            rst_n_q <= (state_d != ST_RST_HOLD);
            cs_n_q  <= !(state_d inside {ST_RST_HOLD, ST_RST_CHECK, ST_HOUSEKEEP,
                                         ST_STREAM, ST_DONE_CHECK, ST_ACTIVATE});
            busy_q  <= (state_d != ST_IDLE);
            op_q    <= (state_d == ST_IDLE) && tgt_done_i;
            if (state_q == ST_IDLE && start_i) begin
                ok_q  <= 1'b0;
                err_q <= ERR_NONE;
            end
            if (err_set) err_q <= err_val;
            if (ok_set)  ok_q  <= 1'b1;
            if (state_q == ST_CS_GAP) begin
                last_seen_q <= 1'b0;
            end else if (accept && in_last_i) begin
                last_seen_q <= 1'b1;
            end
            if (state_q == ST_DONE_CHECK) begin
                pad_left_q <= PW'(ACT_BYTES);
            end else if (state_q == ST_ACTIVATE && tx_load) begin
                pad_left_q <= pad_left_q - 1'b1;
            end
        end
    end

    assign in_ready_o    = ready;
    assign tgt_reset_n_o = rst_n_q;
    assign tgt_cs_n_o    = cs_n_q;
    assign busy_o        = busy_q;
    assign ok_o          = ok_q;
    assign err_o         = err_q;
    assign operating_o   = op_q;

    // R2: chip-select is low whenever the target is held in reset.
    a_r2_cs_low_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_reset_n_o |-> !tgt_cs_n_o);

    // R5: SCLK only toggles inside a chip-select window.
    a_r5_sclk_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sclk_o |-> !tgt_cs_n_o);

    // R10: a result is only presented while idle.
    a_r10_result_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o || err_o != 2'b00) |-> !busy_o);

    // R8: success and an error code never coexist.
    a_r8_ok_excludes_err: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (err_o == 2'b00));

    // R9: a partial request leaves the target lines alone and stays idle.
    a_r9_partial_no_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && partial_i) |=>
            (tgt_reset_n_o && tgt_cs_n_o && !busy_o && err_o == 2'b11));

    // R11: operating is never reported mid-run.
    a_r11_not_operating_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !operating_o);

    // R12: bytes are only taken inside a running chip-select window.
    a_r12_ready_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (busy_o && !tgt_cs_n_o && tgt_reset_n_o));

endmodule

// File: tb/tb_cfg_seq.sv
module tb_cfg_seq;

    localparam int CLK_MHZ = 200;
    localparam int HOLD_NS = 200;
    localparam int HK_US   = 2;
    localparam int HALF    = 4;
    localparam int RST_CYC = (HOLD_NS * CLK_MHZ + 999) / 1000;
    localparam int HK_CYC  = HK_US * CLK_MHZ;
    localparam int GAP_CYC = 2 * HALF;
    localparam int PADS    = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, partial = 1'b0;
    logic [7:0] din = '0;
    logic dvalid = 1'b0, dlast = 1'b0;
    logic tdone = 1'b0;
    logic in_ready, t_rst_n, t_cs_n, t_sclk, t_mosi, busy, ok, operating;
    logic [1:0] err;

    always #2.5 clk = ~clk;

    cfg_seq #(
        .CLK_MHZ(CLK_MHZ), .RESET_HOLD_NS(HOLD_NS), .HOUSEKEEP_US(HK_US),
        .SCLK_HALF(HALF), .ACT_BITS(49)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .partial_i(partial),
        .in_data_i(din), .in_valid_i(dvalid), .in_last_i(dlast),
        .in_ready_o(in_ready), .tgt_reset_n_o(t_rst_n), .tgt_cs_n_o(t_cs_n),
        .tgt_sclk_o(t_sclk), .tgt_mosi_o(t_mosi), .tgt_done_i(tdone),
        .busy_o(busy), .ok_o(ok), .err_o(err), .operating_o(operating)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    logic [2:0] res_q[$];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: offer one byte and push it into the scoreboard.
    task automatic send_byte(input logic [7:0] b, input logic last);
        exp_q.push_back(b);
        din = b; dvalid = 1'b1; dlast = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        dvalid = 1'b0; dlast = 1'b0;
    endtask

    task automatic push_pads();
        for (int i = 0; i < PADS; i++) exp_q.push_back(8'h00);
    endtask

    task automatic pulse_start(input logic p);
        start = 1'b1; partial = p;
        @(negedge clk);
        start = 1'b0; partial = 1'b0;
    endtask

    // Monitor: rebuild bytes from SPI pins, check mode-0 timing, compare results.
    logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_busy = 1'b0;
    logic [7:0] rx_sh = '0;
    int rx_bits = 0, hi_run = 0;
    int mosi_bad = 0, cs_bad = 0, width_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (t_sclk && !prev_sclk) begin
                if (t_cs_n) cs_bad++;
                rx_sh = {rx_sh[6:0], t_mosi};
                rx_bits++;
                if (rx_bits == 8) begin
                    rx_bits = 0;
                    if (exp_q.size() == 0) chk("R8 unexpected SPI byte", rx_sh, 256);
                    else chk("R5 SPI byte", rx_sh, exp_q.pop_front());
                end
            end
            if (t_sclk && prev_sclk && t_mosi != prev_mosi) mosi_bad++;
            if (t_sclk) hi_run++;
            else if (prev_sclk) begin
                if (hi_run != HALF) width_bad++;
                hi_run = 0;
            end
            if (prev_busy && !busy) begin
                if (res_q.size() == 0) chk("R10 unexpected result", {ok, err}, 8);
                else chk("R10 result {ok,err}", {ok, err}, res_q.pop_front());
            end
            prev_sclk = t_sclk; prev_mosi = t_mosi; prev_busy = busy;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R10 reset busy", busy, 0);
        chk("R10 reset ok", ok, 0);
        chk("R10 reset err", err, 0);
        chk("R2 reset cs_n", t_cs_n, 1);
        chk("R1 reset rst_n", t_rst_n, 1);
        chk("R5 reset sclk", t_sclk, 0);
        chk("R12 reset ready", in_ready, 0);
        chk("R11 reset operating", operating, 0);

        // Reset-failed run: done already high
        tdone = 1'b1;
        res_q.push_back(3'b001);
        pulse_start(1'b0);
        chk("R10 busy after start", busy, 1);
        chk("R1 cs low with reset", t_cs_n, 0);
        n = 0;
        while (!t_rst_n) begin
            n++;
            if (t_cs_n) chk("R2 cs under reset", t_cs_n, 0);
            @(negedge clk);
        end
        chk("R1 reset hold cycles", n, RST_CYC);
        chk("R2 cs low at release", t_cs_n, 0);
        @(negedge clk);
        chk("R3 reset-fail code", err, 1);
        chk("R3 cs released", t_cs_n, 1);
        chk("R3 busy low", busy, 0);
        @(negedge clk);
        chk("R11 operating follows done", operating, 1);

        // Successful run
        tdone = 1'b0;
        @(negedge clk);
        chk("R11 operating drops", operating, 0);
        res_q.push_back(3'b100);
        pulse_start(1'b0);
        chk("R10 start clears err", err, 0);
        while (!t_rst_n) @(negedge clk);
        n = 0;
        while (!t_cs_n) begin
            n++;
            if (in_ready) chk("R12 ready in housekeeping", in_ready, 0);
            @(negedge clk);
        end
        chk("R4 cs low after release", n, HK_CYC + 1);
        n = 0;
        while (t_cs_n) begin
            n++;
            if (t_sclk) chk("R4 sclk in gap", t_sclk, 0);
            @(negedge clk);
        end
        chk("R4 cs high gap", n, GAP_CYC);
        chk("R12 ready in stream", in_ready, 1);
        send_byte(8'hA5, 1'b0);
        send_byte(8'h3C, 1'b0);
        send_byte(8'h81, 1'b0);
        send_byte(8'hFF, 1'b1);
        tdone = 1'b1;
        push_pads();
        @(negedge clk);
        chk("R12 ready after last", in_ready, 0);
        while (busy) @(negedge clk);
        chk("R8 ok", ok, 1);
        chk("R8 err none", err, 0);
        chk("R8 cs released", t_cs_n, 1);
        chk("R11 operating after success", operating, 1);
        chk("R8 padding consumed", exp_q.size(), 0);

        // Not-configured run
        tdone = 1'b0;
        @(negedge clk);
        res_q.push_back(3'b010);
        pulse_start(1'b0);
        chk("R10 start clears ok", ok, 0);
        send_byte(8'h12, 1'b0);
        send_byte(8'h34, 1'b1);
        while (busy) @(negedge clk);
        chk("R7 not-configured code", err, 2);
        chk("R7 cs released", t_cs_n, 1);
        chk("R11 operating low", operating, 0);
        repeat (20) @(negedge clk);
        chk("R7 no padding sent", t_sclk, 0);
        chk("R7 scoreboard empty", exp_q.size(), 0);

        // Partial start while a code is held
        pulse_start(1'b1);
        chk("R9 unsupported code", err, 3);
        chk("R9 busy stays low", busy, 0);
        chk("R9 cs unchanged", t_cs_n, 1);
        chk("R9 reset unchanged", t_rst_n, 1);
        repeat (4) @(negedge clk);
        chk("R9 no sclk", t_sclk, 0);
        chk("R9 code held", err, 3);

        // A full start clears the unsupported code
        tdone = 1'b1;
        res_q.push_back(3'b001);
        pulse_start(1'b0);
        chk("R10 full start clears code", err, 0);
        chk("R10 busy raised", busy, 1);
        while (busy) @(negedge clk);
        chk("R3 second reset-fail", err, 1);

        repeat (4) @(negedge clk);
        chk("R5 MOSI steady while SCLK high", mosi_bad, 0);
        chk("R5 CS low at SCLK rise", cs_bad, 0);
        chk("R5 SCLK high width", width_bad, 0);
        chk("R10 results consumed", res_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule